// File: doc/BRIEF.md
# Serial NOR Flash Command Responder

This block behaves as the target side of a four-wire SPI link and emulates a small serial NOR flash. The serial clock idles high. Incoming bits are taken on rising edges and outgoing bits change on falling edges, most significant bit first. All four bus pins are brought into the core clock domain through short synchronizers. The core clock must run several times faster than the serial clock.

The first byte of each select window is an opcode. It selects which address, dummy, data-in or data-out bytes follow. Storage is an internal byte array that holds 0xFF after reset. Reads stream without limit. Page program ANDs new bytes into the array. Sector erase and bulk erase return bytes to 0xFF. A status byte carries a write-enable latch, and a deep power-down mode accepts only the signature opcode.

Commands that change state take effect when the select is released, with one exception: page-program data is merged byte by byte as it arrives.

Top module: `serflash_resp`

## Requirements
- R1: `sdo` holds 1 while `sel_n` is high and changes only after a falling `sclk` edge. Every byte on `sdi` and `sdo` is sent most significant bit first, and `sdi` is sampled on rising `sclk` edges.
- R2: Opcode 0x05 returns the status byte in every byte that follows. Bit 0 always reads 0 (never busy), bit 1 is the write-enable latch and bits 7:2 are the stored status value. All status bits are 0 after reset.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect when the select is released.
- R4: Opcode 0x01 followed by one byte copies bits 7:2 of that byte into the status value. It does this only if the latch is set, and it never changes bits 1:0 directly.
- R5: Opcode 0x03 is followed by three address bytes, high byte first. Data starts in the next byte from the array index formed by the low log2(MEM_BYTES) bits of that 24-bit address.
- R6: While select stays low during a read, the index advances by one per returned byte and wraps from the last byte of the array to index 0.
- R7: Opcode 0x0B behaves like 0x03 but ignores one dummy byte after the address before data begins.
- R8: Opcode 0x02 followed by three address bytes ANDs each following byte into the addressed array byte. After each byte only the low log2(PAGE_BYTES) index bits advance, so writes wrap within the page.
- R9: The array holds 0xFF after reset. Opcode 0xD8 plus three address bytes sets the aligned SECTOR_BYTES block holding the address to 0xFF and leaves other blocks untouched. Opcode 0xC7 sets the whole array to 0xFF.
- R10: Opcodes 0x02, 0xD8, 0xC7 and 0x01 change neither the array nor the status while the latch is clear. Once their mandatory bytes are complete, each clears the latch on release.
- R11: After opcode 0xB9 and release, every opcode except 0xAB is ignored: `sdo` stays 1 and no state changes. Receiving 0xAB leaves power-down.
- R12: Opcode 0xAB followed by three dummy bytes returns SIG_BYTE (default 0x13), in power-down or not.
- R13: An unknown opcode makes the rest of the select window return 0xFF with no effect. A command released before its mandatory bytes are complete has no effect, and the latch stays as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the bus controller, idles high |
| sel_n | input | 1 | Active-low select framing one command |
| sdi | input | 1 | Serial data into the responder |
| sdo | output | 1 | Serial data out of the responder |

## Verification
The bench builds the block with its defaults: a 512-byte array, 256-byte pages, 64-byte sectors and two synchronizer stages. With a 9-bit index, the upper bits of a 24-bit address are visibly discarded, and a read started at 0x1FF crosses the array end after a single byte. Two pages let a page-program wrap land on a byte that differs from where an array wrap would put it. Eight sectors let a sector erase be checked against an untouched neighbouring sector.

// File: rtl/serflash_pkg.sv
package serflash_pkg;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_FREAD = 8'h0B;
   localparam logic [7:0] OP_PP    = 8'h02;
   localparam logic [7:0] OP_SE    = 8'hD8;
   localparam logic [7:0] OP_BE    = 8'hC7;
   localparam logic [7:0] OP_DP    = 8'hB9;
   localparam logic [7:0] OP_RES   = 8'hAB;

   // byte-phase of the command currently framed by select
   typedef enum logic [3:0] {
      PH_OPC,    // expecting opcode
      PH_ADDR,   // three address or dummy bytes
      PH_DUMMY,  // fast-read gap byte
      PH_DOUT,   // streaming array data
      PH_PROG,   // page data arriving
      PH_SRDAT,  // new status byte arriving
      PH_STOUT,  // returning status
      PH_SIGOUT, // returning signature
      PH_HOLD,   // complete, waiting for release
      PH_SKIP    // ignored until release
   } phase_e;
endpackage

// File: rtl/serflash_pinsync.sv
module serflash_pinsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic sel_n,
   input  logic sdi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_act,
   output logic cs_end,
   output logic sdi_s
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("serflash_pinsync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] sck_p, sel_p, sdi_p;
   logic sck_d, sel_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p <= '1;
         sel_p <= '1;
         sdi_p <= '0;
         sck_d <= 1'b1;
         sel_d <= 1'b1;
      end else begin
         sck_p <= STAGES'({sck_p, sclk});
         sel_p <= STAGES'({sel_p, sel_n});
         sdi_p <= STAGES'({sdi_p, sdi});
         sck_d <= sck_p[STAGES-1];
         sel_d <= sel_p[STAGES-1];
      end
   end

   assign sck_rise = sck_p[STAGES-1] & ~sck_d;
   assign sck_fall = ~sck_p[STAGES-1] & sck_d;
   assign cs_act   = ~sel_p[STAGES-1];
   assign cs_end   = sel_p[STAGES-1] & ~sel_d;
   assign sdi_s    = sdi_p[STAGES-1];
endmodule

// File: rtl/serflash_shift.sv
module serflash_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       rise,
   input  logic       fall,
   input  logic       sdi_s,
   input  logic       load,
   input  logic [7:0] load_byte,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sdo
);
   logic [2:0] cnt;
   logic [7:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         rx_byte <= '0;
         tx_sh   <= 8'hFF;
         sdo     <= 1'b1;
         done    <= 1'b0;
      end else if (!active) begin
         cnt   <= '0;
         tx_sh <= 8'hFF;
         sdo   <= 1'b1;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (rise) begin
            rx_byte <= {rx_byte[6:0], sdi_s};
            cnt     <= cnt + 3'd1;
            done    <= (cnt == 3'd7);
         end
         if (fall) begin
            sdo   <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b1};
         end
         if (load) tx_sh <= load_byte;
      end
   end
endmodule

// File: rtl/serflash_array.sv
module serflash_array #(
   parameter  int BYTES  = 512,
   parameter  int SECTOR = 64,
   localparam int AW     = $clog2(BYTES),
   localparam int SW     = $clog2(SECTOR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    rd_idx,
   output logic [7:0]       rd_byte,
   input  logic             prog_en,
   input  logic [AW-1:0]    prog_idx,
   input  logic [7:0]       prog_byte,
   input  logic             erase_all,
   input  logic             erase_sec,
   input  logic [AW-SW-1:0] sec_sel
);
   logic [BYTES-1:0][7:0] flat;

   for (genvar g = 0; g < BYTES; g++) begin : g_cell
      localparam logic [AW-1:0] IDX = AW'(g);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 8'hFF;
         else if (erase_all || (erase_sec && sec_sel == IDX[AW-1:SW]))
            q <= 8'hFF;
         else if (prog_en && prog_idx == IDX)
            q <= q & prog_byte;
      end
      assign flat[g] = q;
   end

   assign rd_byte = flat[rd_idx];
endmodule

// File: rtl/serflash_resp.sv
module serflash_resp
   import serflash_pkg::*;
#(
   parameter int         MEM_BYTES    = 512,
   parameter int         PAGE_BYTES   = 256,
   parameter int         SECTOR_BYTES = 64,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [7:0] SIG_BYTE     = 8'h13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic sel_n,
   input  logic sdi,
   output logic sdo
);
   localparam int AW = $clog2(MEM_BYTES);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam int SW = $clog2(SECTOR_BYTES);

   generate
      if (MEM_BYTES != (1 << AW) || AW > 24)
         begin : g_bad_mem $error("MEM_BYTES must be a power of two up to 2^24"); end
      if (PAGE_BYTES != (1 << PW) || PAGE_BYTES > MEM_BYTES)
         begin : g_bad_page $error("PAGE_BYTES must be a power of two within the array"); end
      if (SECTOR_BYTES != (1 << SW) || SECTOR_BYTES >= MEM_BYTES)
         begin : g_bad_sec $error("SECTOR_BYTES must be a power of two below MEM_BYTES"); end
   endgenerate

   logic sck_rise, sck_fall, cs_act, cs_end, sdi_s;
   logic byte_done, load;
   logic [7:0] rx_byte, load_byte, rd_byte, status;
   logic prog_en, erase_all, erase_sec;

   phase_e        phase_q;
   logic [7:0]    cmd_q;
   logic [AW-1:0] ptr_q, ptr_shift, prog_next, rd_idx;
   logic [1:0]    cnt_q;
   logic          armed_q, wel_q, pd_q;
   logic [5:0]    st_hi_q, sr_new_q;

   serflash_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
      .cs_end(cs_end), .sdi_s(sdi_s));

   serflash_shift u_shift (
      .clk(clk), .rst_n(rst_n), .active(cs_act), .rise(sck_rise),
      .fall(sck_fall), .sdi_s(sdi_s), .load(load), .load_byte(load_byte),
      .done(byte_done), .rx_byte(rx_byte), .sdo(sdo));

   serflash_array #(.BYTES(MEM_BYTES), .SECTOR(SECTOR_BYTES)) u_array (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_byte(rd_byte),
      .prog_en(prog_en), .prog_idx(ptr_q), .prog_byte(rx_byte),
      .erase_all(erase_all), .erase_sec(erase_sec), .sec_sel(ptr_q[AW-1:SW]));

   assign status    = {st_hi_q, wel_q, 1'b0};
   assign ptr_shift = AW'({ptr_q, rx_byte});
   assign rd_idx    = (phase_q == PH_ADDR) ? ptr_shift : ptr_q;

   generate
      if (PW == AW) begin : g_flat_page
         assign prog_next = ptr_q + AW'(1);
      end else begin : g_split_page
         assign prog_next = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
      end
   endgenerate

   // byte to present next and array strobes
   always_comb begin
      load      = 1'b0;
      load_byte = 8'hFF;
      prog_en   = 1'b0;
      erase_all = 1'b0;
      erase_sec = 1'b0;
      if (cs_act && byte_done) begin
         case (phase_q)
            PH_OPC: if (rx_byte == OP_RDSR && !pd_q) begin
               load = 1'b1; load_byte = status;
            end
            PH_ADDR: if (cnt_q == 2'd2) begin
               if (cmd_q == OP_READ) begin
                  load = 1'b1; load_byte = rd_byte;
               end else if (cmd_q == OP_RES) begin
                  load = 1'b1; load_byte = SIG_BYTE;
               end
            end
            PH_DUMMY, PH_DOUT: begin load = 1'b1; load_byte = rd_byte; end
            PH_STOUT:          begin load = 1'b1; load_byte = status; end
            PH_SIGOUT:         begin load = 1'b1; load_byte = SIG_BYTE; end
            PH_PROG:           prog_en = wel_q;
            default: ;
         endcase
      end
      if (cs_end && armed_q && wel_q) begin
         erase_all = (cmd_q == OP_BE);
         erase_sec = (cmd_q == OP_SE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_OPC;
         cmd_q    <= '0;
         ptr_q    <= '0;
         cnt_q    <= '0;
         armed_q  <= 1'b0;
         wel_q    <= 1'b0;
         pd_q     <= 1'b0;
         st_hi_q  <= '0;
         sr_new_q <= '0;
      end else if (!cs_act) begin
         if (cs_end && armed_q) begin
            case (cmd_q)
               OP_WREN: wel_q <= 1'b1;
               OP_WRDI: wel_q <= 1'b0;
               OP_DP:   pd_q  <= 1'b1;
               OP_WRSR: begin
                  if (wel_q) st_hi_q <= sr_new_q;
                  wel_q <= 1'b0;
               end
               OP_PP, OP_SE, OP_BE: wel_q <= 1'b0;
               default: ;
            endcase
         end
         phase_q <= PH_OPC;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (byte_done) begin
         case (phase_q)
            PH_OPC: begin
               cmd_q <= rx_byte;
               cnt_q <= '0;
               if (pd_q && rx_byte != OP_RES) phase_q <= PH_SKIP;
               else begin
                  case (rx_byte)
                     OP_WREN, OP_WRDI, OP_BE, OP_DP: begin
                        phase_q <= PH_HOLD; armed_q <= 1'b1;
                     end
                     OP_WRSR: phase_q <= PH_SRDAT;
                     OP_RDSR: phase_q <= PH_STOUT;
                     OP_READ, OP_FREAD, OP_PP, OP_SE: phase_q <= PH_ADDR;
                     OP_RES: begin phase_q <= PH_ADDR; pd_q <= 1'b0; end
                     default: phase_q <= PH_SKIP;
                  endcase
               end
            end
            PH_ADDR: begin
               ptr_q <= ptr_shift;
               cnt_q <= cnt_q + 2'd1;
               if (cnt_q == 2'd2) begin
                  case (cmd_q)
                     OP_READ:  begin phase_q <= PH_DOUT; ptr_q <= ptr_shift + AW'(1); end
                     OP_FREAD: phase_q <= PH_DUMMY;
                     OP_PP:    phase_q <= PH_PROG;
                     OP_SE:    begin phase_q <= PH_HOLD; armed_q <= 1'b1; end
                     OP_RES:   phase_q <= PH_SIGOUT;
                     default:  phase_q <= PH_SKIP;
                  endcase
               end
            end
            PH_DUMMY: begin phase_q <= PH_DOUT; ptr_q <= ptr_q + AW'(1); end
            PH_DOUT:  ptr_q <= ptr_q + AW'(1);
            PH_PROG:  begin ptr_q <= prog_next; armed_q <= 1'b1; end
            PH_SRDAT: begin
               sr_new_q <= rx_byte[7:2];
               armed_q  <= 1'b1;
               phase_q  <= PH_HOLD;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/serflash_chk.sv
module serflash_chk
   import serflash_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cs_act,
   input logic       cs_end,
   input logic       sck_rise,
   input logic       sck_fall,
   input logic       byte_done,
   input logic [7:0] rx_byte,
   input phase_e     phase,
   input logic [7:0] cmd,
   input logic       armed,
   input logic       wel,
   input logic       pd,
   input logic       sdo
);
   p_sdo_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> sdo);

   p_sdo_only_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !sck_fall) |=> $stable(sdo));

   p_byte_after_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> $past(sck_rise));

   p_wel_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && armed && cmd == OP_WREN) |=> wel);

   p_wel_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && armed && (cmd == OP_PP || cmd == OP_SE || cmd == OP_BE || cmd == OP_WRSR))
      |=> !wel);

   p_pd_enter_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && armed && cmd == OP_DP) |=> pd);

   p_pd_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && pd && byte_done && phase == PH_OPC && rx_byte != OP_RES)
      |=> phase == PH_SKIP);
endmodule

bind serflash_resp serflash_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_end(cs_end),
   .sck_rise(sck_rise), .sck_fall(sck_fall), .byte_done(byte_done),
   .rx_byte(rx_byte), .phase(phase_q), .cmd(cmd_q), .armed(armed_q),
   .wel(wel_q), .pd(pd_q), .sdo(sdo));

// File: tb/serflash_resp_test.sv
`timescale 1ns/1ps
module serflash_resp_test;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n, sclk, sel_n, sdi, sdo;
   int   checks = 0;
   int   failures = 0;
   bit   done_flag = 1'b0;

   logic [7:0] exp_q [$];
   logic [7:0] got_q [$];
   string      tag_q [$];

   always #2.5 clk = ~clk;

   serflash_resp uut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n),
      .sdi(sdi), .sdo(sdo));

   // monitor: pairs every captured byte with its expectation
   always @(negedge clk) begin
      logic [7:0] g, e;
      string t;
      while (got_q.size() > 0 && exp_q.size() > 0) begin
         g = got_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (g !== e) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", t, g, e);
         end
      end
   end

   task automatic chk_bit(input logic act, input logic exp, input string t);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", t, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         sclk = 1'b0;
         sdi  = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = sdo;
         sclk  = 1'b1;
         repeat (HALF - 1) @(negedge clk);
      end
   endtask

   task automatic send(input logic [7:0] b);
      logic [7:0] r;
      xfer(b, r);
   endtask

   // driver side of the scoreboard
   task automatic expect_byte(input logic [7:0] e, input string t);
      logic [7:0] r;
      exp_q.push_back(e);
      tag_q.push_back(t);
      xfer(8'hFF, r);
      got_q.push_back(r);
   endtask

   task automatic sel_on();
      @(negedge clk); sel_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic sel_off();
      repeat (4) @(negedge clk);
      sel_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic one_op(input logic [7:0] op);
      sel_on(); send(op); sel_off();
   endtask

   task automatic addr_cmd(input logic [7:0] op, input logic [23:0] a);
      sel_on(); send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
   endtask

   task automatic status_is(input logic [7:0] e, input string t);
      sel_on(); send(8'h05); expect_byte(e, t); expect_byte(e, t); sel_off();
   endtask

   initial begin
      rst_n = 1'b0; sclk = 1'b1; sel_n = 1'b1; sdi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      chk_bit(sdo, 1'b1, "R1 idle sdo after reset");
      status_is(8'h00, "R2 reset status");
      addr_cmd(8'h03, 24'h000010); expect_byte(8'hFF, "R9 erased after reset"); sel_off();

      one_op(8'h06); status_is(8'h02, "R3 latch set");
      one_op(8'h04); status_is(8'h00, "R3 latch cleared");

      addr_cmd(8'h02, 24'h000010); send(8'h12); sel_off();
      addr_cmd(8'h03, 24'h000010); expect_byte(8'hFF, "R10 program without latch"); sel_off();

      one_op(8'h06);
      addr_cmd(8'h02, 24'h000010); send(8'hA5); send(8'h3C); sel_off();
      status_is(8'h00, "R10 latch cleared by program");
      addr_cmd(8'h03, 24'h000010);
      expect_byte(8'hA5, "R5 read first byte");
      expect_byte(8'h3C, "R6 read increments");
      expect_byte(8'hFF, "R6 read increments");
      sel_off();

      one_op(8'h06);
      addr_cmd(8'h02, 24'h000010); send(8'h0F); sel_off();
      addr_cmd(8'h03, 24'h000010); expect_byte(8'h05, "R8 program ANDs"); sel_off();

      one_op(8'h06);
      addr_cmd(8'h02, 24'h000000); send(8'h77); sel_off();
      one_op(8'h06);
      addr_cmd(8'h02, 24'hABC1FE); send(8'h11); send(8'h22); send(8'h33); sel_off();
      addr_cmd(8'h03, 24'hABC1FE);
      expect_byte(8'h11, "R5 upper address bits dropped");
      expect_byte(8'h22, "R5 upper address bits dropped");
      sel_off();
      addr_cmd(8'h03, 24'h0001FF);
      expect_byte(8'h22, "R6 last array byte");
      expect_byte(8'h77, "R6 wrap to index 0");
      sel_off();
      addr_cmd(8'h03, 24'h000100); expect_byte(8'h33, "R8 page wrap"); sel_off();

      addr_cmd(8'h0B, 24'h000010); send(8'h00);
      expect_byte(8'h05, "R7 fast read after dummy");
      expect_byte(8'h3C, "R7 fast read stream");
      sel_off();

      sel_on(); send(8'h01); send(8'hFC); sel_off();
      status_is(8'h00, "R10 status write without latch");
      one_op(8'h06);
      sel_on(); send(8'h01); send(8'hFF); sel_off();
      status_is(8'hFC, "R4 status write");
      one_op(8'h06);
      status_is(8'hFE, "R4 latch bit live");
      one_op(8'h04);

      addr_cmd(8'hD8, 24'h000100); sel_off();
      addr_cmd(8'h03, 24'h000100); expect_byte(8'h33, "R10 sector erase without latch"); sel_off();
      one_op(8'h06);
      addr_cmd(8'hD8, 24'h000011); sel_off();
      addr_cmd(8'h03, 24'h000010);
      expect_byte(8'hFF, "R9 sector erased");
      expect_byte(8'hFF, "R9 sector erased");
      sel_off();
      addr_cmd(8'h03, 24'h0001FF);
      expect_byte(8'h22, "R9 other sector kept");
      expect_byte(8'hFF, "R9 index 0 erased");
      sel_off();
      addr_cmd(8'h03, 24'h000100); expect_byte(8'h33, "R9 other sector kept"); sel_off();

      one_op(8'hC7);
      addr_cmd(8'h03, 24'h0001FE); expect_byte(8'h11, "R10 bulk erase without latch"); sel_off();
      one_op(8'h06); one_op(8'hC7);
      addr_cmd(8'h03, 24'h0001FE);
      expect_byte(8'hFF, "R9 bulk erased");
      expect_byte(8'hFF, "R9 bulk erased");
      sel_off();
      addr_cmd(8'h03, 24'h000100); expect_byte(8'hFF, "R9 bulk erased"); sel_off();

      one_op(8'hB9);
      sel_on(); send(8'h05); expect_byte(8'hFF, "R11 ignored in power-down"); sel_off();
      one_op(8'h06);
      addr_cmd(8'hAB, 24'h000000); expect_byte(8'h13, "R12 signature wakes"); sel_off();
      status_is(8'hFC, "R11 opcode ignored in power-down");

      addr_cmd(8'hAB, 24'h123456); expect_byte(8'h13, "R12 signature awake"); sel_off();

      sel_on(); send(8'h9F);
      expect_byte(8'hFF, "R13 unknown opcode");
      expect_byte(8'hFF, "R13 unknown opcode");
      sel_off();
      one_op(8'h06);
      sel_on(); send(8'hD8); send(8'h00); send(8'h01); sel_off();
      status_is(8'hFE, "R13 partial command no effect");
      chk_bit(sdo, 1'b1, "R1 idle sdo between commands");

      repeat (20) @(negedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule